// File: doc/BRIEF.md
# Synchronous-to-Asynchronous Receive Rate Converter

This block sits on the receive side between a synchronous bit stream, delivered at the nominal line rate with a one-cycle strobe per bit, and an asynchronous terminal line. It reframes each received character and queues it in a small FIFO. It then plays the character out with its own bit timing. Far-end transmitters that run slightly fast drop a stop bit now and then. When the converter finds a start bit where a stop bit should be, it treats that bit as the start of the next character and puts a full stop bit back on the output.

Output bit timing comes from a fractional phase accumulator clocked by the system clock. In normal mode the output runs no more than 1% above nominal. An extended mode allows up to 2.3% above nominal and shortens each output stop bit to 7/8 of a bit time. A break, meaning the line held low for two whole character times, reaches the output as a continuous low with no stop bit inserted in it. A bypass select covers the modes in which no conversion is wanted: the input line and strobe go straight to the output.

Top module: `sync_async_rx_conv`

## Requirements
- R1: After reset the output line is high (mark) and the output strobe is low.
- R2: Each character leaves as a start bit (0), then its data bits least significant first, then a stop bit (1). The output strobe pulses for one cycle as each bit begins. The character length code sets the total bits per character including start and stop: 0→8, 1→9, 2→10, 3→11. The data width is 6 plus the code.
- R3: When the input holds a 0 in the stop position and the character's data is not all zero, the character is output with a stop bit of 1. That 0 is taken as the start bit of the next character.
- R4: In normal mode each output start or data bit lasts at least floor(NOM_CYC·100/101) and at most NOM_CYC system cycles. A stop bit followed by a queued character lasts at least floor(NOM_CYC·100/101) cycles.
- R5: In extended mode, start and data bits last at least floor(NOM_CYC·1000/1023) and at most NOM_CYC cycles. With the next character already queued, the time from a stop bit's strobe to the next start strobe lies between floor(7·NOM_CYC·1000/(8·1023)) and that value plus 2.
- R6: A character with all-zero data and a 0 in the stop position is a break. Its stop slot is output low. The output stays low from one break character into the next. The output returns high only after the input line has returned high.
- R7: While bypass is high, the output line and strobe equal the input line and strobe in the same cycle. The framing state is cleared, so a partly received character produces no output after bypass drops.
- R8: Characters are output in the order received, and each output stop bit is high except for a break.
- R9: An idle input (high, with no start bit) produces no output strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received synchronous data bit |
| rx_stb | input | 1 | One-cycle strobe marking each received bit at the nominal rate |
| char_len | input | 2 | Character length code (0..3 → 8..11 bits) |
| ext_ovr | input | 1 | Extended overspeed select (shortened stop bits) |
| bypass | input | 1 | Pass input straight to output |
| tx_line | output | 1 | Asynchronous output data line |
| tx_stb | output | 1 | One-cycle strobe at the start of each output bit |

## Verification
The bench sends streams that delete stop bits back to back. This fills the FIFO and forces stop-to-start gaps at the shortest legal spacing. A design that misses the deleted stop would shift every following character by one bit. A design that shortens stop bits in normal mode, or fails to shorten them in extended mode, would miss the gap bounds. Breaks of exactly two character times are sent to catch a design that inserts a high stop slot or a high glitch between the two break characters. Bypass is raised with a character half received, which exposes framing state left behind after bypass drops.

// File: rtl/s2a_pkg.sv
package s2a_pkg;
    localparam int MAX_DATA = 9;

    typedef logic [1:0] len_code_t;

    typedef struct packed {
        logic                brk;
        logic [MAX_DATA-1:0] data;
    } s2a_char_t;

    typedef enum logic [1:0] {DF_IDLE, DF_DATA, DF_STOP} df_state_t;
    typedef enum logic [1:0] {SR_IDLE, SR_START, SR_DATA, SR_STOP} sr_state_t;

    function automatic logic [3:0] data_bits(len_code_t code);
        return 4'd6 + {2'b00, code};
    endfunction
endpackage

// File: rtl/s2a_deframer.sv
module s2a_deframer
    import s2a_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      rx_bit,
    input  logic      rx_stb,
    input  len_code_t char_len,
    output logic      push,
    output s2a_char_t push_char,
    output logic      mark
);
    df_state_t           st;
    logic [3:0]          cnt;
    logic [MAX_DATA-1:0] sh;
    logic [3:0]          last_idx;

    assign last_idx = data_bits(char_len) - 4'd1;

    always_comb begin
        push           = rx_stb && (st == DF_STOP);
        push_char.data = sh;
        push_char.brk  = !rx_bit && (sh == '0);
        mark           = rx_stb && rx_bit && (st == DF_IDLE);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            st  <= DF_IDLE;
            cnt <= '0;
            sh  <= '0;
        end else if (rx_stb) begin
            case (st)
                DF_IDLE: if (!rx_bit) begin
                    st  <= DF_DATA;
                    cnt <= '0;
                    sh  <= '0;
                end
                DF_DATA: begin
                    sh[cnt] <= rx_bit;
                    if (cnt == last_idx) st <= DF_STOP;
                    else                 cnt <= cnt + 4'd1;
                end
                DF_STOP: begin
                    cnt <= '0;
                    sh  <= '0;
                    // a 0 here with live data is the next start bit (deleted stop)
                    if (rx_bit || sh == '0) st <= DF_IDLE;
                    else                    st <= DF_DATA;
                end
                default: st <= DF_IDLE;
            endcase
        end
    end

    // R3: a deleted stop bit opens the next character at once
    p_deleted_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && push && !push_char.brk && !rx_bit) |=> (st == DF_DATA || clr));
endmodule

// File: rtl/s2a_fifo.sv
module s2a_fifo
    import s2a_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      push,
    input  s2a_char_t wdata,
    input  logic      pop,
    output s2a_char_t rdata,
    output logic      empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    s2a_char_t       mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            wr, rd;

    assign empty = (cnt == '0);
    assign wr    = push && (cnt != CW'(DEPTH));
    assign rd    = pop && !empty;
    assign rdata = mem[rp];

    always_ff @(posedge clk) begin
        if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr) begin
                mem[wp] <= wdata;
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            end
            if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            cnt <= cnt + CW'(wr) - CW'(rd);
        end
    end

    // R8: the player never takes a character that is not there
    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0));
endmodule

// File: rtl/s2a_serializer.sv
module s2a_serializer
    import s2a_pkg::*;
#(
    parameter int NOM_CYC = 40,
    parameter int ACC_W   = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      ext_ovr,
    input  len_code_t char_len,
    input  logic      mark,
    input  logic      fifo_empty,
    input  s2a_char_t fifo_char,
    output logic      pop,
    output logic      line,
    output logic      stb
);
    localparam int    AW1     = ACC_W + 1;
    localparam longint ONE    = longint'(1) << ACC_W;
    localparam logic [ACC_W:0] INC_N  = AW1'((ONE * 101) / (100 * NOM_CYC));
    localparam logic [ACC_W:0] INC_E  = AW1'((ONE * 1023) / (1000 * NOM_CYC));
    localparam logic [ACC_W:0] LIM_F  = AW1'(ONE);
    localparam logic [ACC_W:0] LIM_SE = AW1'((ONE * 7) / 8);
    localparam int    MIN_GAP = int'(((ONE * 7) / 8) / ((ONE * 1023) / (1000 * NOM_CYC)));
    localparam int    GW      = $clog2(4 * NOM_CYC + 2);
    localparam logic [GW-1:0] GMAX = '1;

    sr_state_t       st;
    s2a_char_t       cur;
    logic [ACC_W:0]  acc, inc, lim, sum;
    logic [3:0]      idx, last_idx;
    logic            tick, hold_low, mark_pend;
    logic [GW-1:0]   gap;

    assign last_idx = data_bits(char_len) - 4'd1;

    always_comb begin
        inc  = ext_ovr ? INC_E : INC_N;
        lim  = (st == SR_STOP && ext_ovr && !cur.brk) ? LIM_SE : LIM_F;
        sum  = acc + inc;
        tick = (sum >= lim);
        pop  = (st == SR_IDLE) && !fifo_empty;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            st        <= SR_IDLE;
            cur       <= '0;
            acc       <= '0;
            idx       <= '0;
            line      <= 1'b1;
            stb       <= 1'b0;
            hold_low  <= 1'b0;
            mark_pend <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (pop)  mark_pend <= 1'b0;
            if (mark) mark_pend <= 1'b1;
            case (st)
                SR_IDLE: begin
                    if (pop) begin
                        cur      <= fifo_char;
                        st       <= SR_START;
                        acc      <= '0;
                        line     <= 1'b0;
                        stb      <= 1'b1;
                        hold_low <= 1'b0;
                    end else begin
                        if (hold_low && mark_pend) hold_low <= 1'b0;
                        line <= !(hold_low && !mark_pend);
                    end
                end
                SR_START: begin
                    if (tick) begin
                        acc  <= sum - lim;
                        st   <= SR_DATA;
                        idx  <= '0;
                        line <= cur.data[0];
                        stb  <= 1'b1;
                    end else acc <= sum;
                end
                SR_DATA: begin
                    if (tick) begin
                        acc <= sum - lim;
                        stb <= 1'b1;
                        if (idx == last_idx) begin
                            st   <= SR_STOP;
                            line <= !cur.brk;
                        end else begin
                            idx  <= idx + 4'd1;
                            line <= cur.data[idx + 4'd1];
                        end
                    end else acc <= sum;
                end
                SR_STOP: begin
                    if (tick) begin
                        st  <= SR_IDLE;
                        acc <= '0;
                        if (cur.brk) begin
                            hold_low <= !mark_pend;
                            line     <= mark_pend;
                        end else line <= 1'b1;
                    end else acc <= sum;
                end
                default: st <= SR_IDLE;
            endcase
        end
    end

    // spacing monitor for the rate assertion
    always_ff @(posedge clk) begin
        if (clr)             gap <= GMAX;
        else if (stb)        gap <= GW'(1);
        else if (gap != GMAX) gap <= gap + GW'(1);
    end

    // R4/R5: no two bit strobes closer than the shortest legal bit
    p_rate_limit_r4: assert property (@(posedge clk) disable iff (rst)
        stb |-> (int'(gap) >= MIN_GAP));
    // R8: a regular stop slot stays high
    p_stop_high_r8: assert property (@(posedge clk) disable iff (rst)
        (st == SR_STOP && !cur.brk) |-> line);
    // R6: a break never gets a high stop slot
    p_break_low_r6: assert property (@(posedge clk) disable iff (rst)
        (st == SR_STOP && cur.brk) |-> !line);
endmodule

// File: rtl/sync_async_rx_conv.sv
module sync_async_rx_conv
    import s2a_pkg::*;
#(
    parameter int NOM_CYC = 40,
    parameter int ACC_W   = 16,
    parameter int DEPTH   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       rx_stb,
    input  logic [1:0] char_len,
    input  logic       ext_ovr,
    input  logic       bypass,
    output logic       tx_line,
    output logic       tx_stb
);
    logic      clr, push, pop, mark, empty, ser_line, ser_stb;
    s2a_char_t in_char, out_char;

    assign clr = rst || bypass;

    s2a_deframer u_deframer (
        .clk(clk), .rst(rst), .clr(clr), .rx_bit(rx_bit), .rx_stb(rx_stb),
        .char_len(char_len), .push(push), .push_char(in_char), .mark(mark)
    );

    s2a_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .clr(clr), .push(push), .wdata(in_char),
        .pop(pop), .rdata(out_char), .empty(empty)
    );

    s2a_serializer #(.NOM_CYC(NOM_CYC), .ACC_W(ACC_W)) u_ser (
        .clk(clk), .rst(rst), .clr(clr), .ext_ovr(ext_ovr), .char_len(char_len),
        .mark(mark), .fifo_empty(empty), .fifo_char(out_char),
        .pop(pop), .line(ser_line), .stb(ser_stb)
    );

    assign tx_line = bypass ? rx_bit : ser_line;
    assign tx_stb  = bypass ? rx_stb : ser_stb;

    // R1: mark state straight after reset
    p_reset_mark_r1: assert property (@(posedge clk)
        (rst && !bypass) |=> (bypass || (tx_line && !tx_stb)));
endmodule

// File: tb/sync_async_rx_conv_tb.sv
module sync_async_rx_conv_tb;
    localparam int NOM = 40;
    localparam int LO_N  = (NOM * 100) / 101;
    localparam int LO_E  = (NOM * 1000) / 1023;
    localparam int LO_SE = (7 * NOM * 1000) / (8 * 1023);

    logic clk = 0, rst = 1, rx_bit = 1, rx_stb = 0, ext_ovr = 0, bypass = 0;
    logic [1:0] char_len = 2'd2;
    logic tx_line, tx_stb;

    int checks = 0, errors = 0;
    logic [9:0] exp_q[$];
    int mon_pos = -1, cyc = 0, last_stb = 0, stb_seen = 0;
    logic [8:0] mdata;
    bit have_prev = 0, prev_brk = 0, hi_seen = 0, burst = 0;
    int min_stop = 1000;

    always #2 clk = ~clk;

    sync_async_rx_conv #(.NOM_CYC(NOM)) u_dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_stb(rx_stb),
        .char_len(char_len), .ext_ovr(ext_ovr), .bypass(bypass),
        .tx_line(tx_line), .tx_stb(tx_stb)
    );

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int nbits();
        return 6 + int'(char_len);
    endfunction

    // output monitor: frames characters and times every bit
    always @(negedge clk) begin
        int gap;
        logic [9:0] e;
        cyc++;
        if (rst || bypass) begin
            mon_pos = -1; last_stb = cyc; hi_seen = 0; have_prev = 0;
        end else if (tx_stb) begin
            stb_seen++;
            gap = cyc - last_stb;
            last_stb = cyc;
            if (mon_pos == -1) begin
                chk(tx_line == 1'b0, "R2 start bit", tx_line, 0);
                if (exp_q.size() == 0)
                    chk(0, "R9 unexpected character", 1, 0);
                else if (have_prev && prev_brk && exp_q[0][9])
                    chk(!hi_seen, "R6 break stays low", hi_seen, 0);
                if (have_prev && !prev_brk) begin
                    chk(gap >= (ext_ovr ? LO_SE : LO_N),
                        ext_ovr ? "R5 stop min" : "R4 stop min", gap,
                        ext_ovr ? LO_SE : LO_N);
                    if (ext_ovr && burst && gap < min_stop) min_stop = gap;
                end
                mon_pos = 0; mdata = '0;
            end else begin
                chk(gap >= (ext_ovr ? LO_E : LO_N) && gap <= NOM,
                    ext_ovr ? "R5 bit time" : "R4 bit time", gap,
                    ext_ovr ? LO_E : LO_N);
                if (mon_pos < nbits()) begin
                    mdata[mon_pos] = tx_line;
                    mon_pos++;
                end else begin
                    if (exp_q.size() != 0) begin
                        e = exp_q.pop_front();
                        chk(mdata == e[8:0], "R2/R3/R8 data order", mdata, e[8:0]);
                        chk(tx_line == !e[9], "R8/R6 stop slot", tx_line, !e[9]);
                        prev_brk = e[9];
                    end
                    have_prev = 1; mon_pos = -1; hi_seen = 0;
                end
            end
        end else if (tx_line) hi_seen = 1;
    end

    task automatic send_bit(logic b);
        @(negedge clk); rx_bit = b; rx_stb = 1;
        @(negedge clk); rx_stb = 0;
        repeat (NOM - 2) @(negedge clk);
    endtask

    task automatic send_idle(int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_char(logic [8:0] d, bit del);
        logic [8:0] m;
        m = 9'h1FF >> (9 - nbits());
        d = d & m;
        if (del && d == 0) d = 9'd1;
        exp_q.push_back({1'b0, d});
        send_bit(1'b0);
        for (int i = 0; i < nbits(); i++) send_bit(d[i]);
        if (!del) send_bit(1'b1);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || mon_pos != -1) @(negedge clk);
        repeat (3 * NOM) @(negedge clk);
    endtask

    task automatic random_run(int n, int del_mod);
        for (int k = 0; k < n; k++) begin
            bit del;
            del = (k != n - 1) && ($urandom % del_mod == 0);
            send_char(9'($urandom), del);
            if (!del) send_idle($urandom % 3);
        end
        send_idle(2);
        drain();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2417));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1 reset line", tx_line, 1);
        chk(tx_stb == 1'b0, "R1 reset strobe", tx_stb, 0);

        // R9: idle input gives nothing
        send_idle(20);
        chk(stb_seen == 0, "R9 idle strobes", stb_seen, 0);

        // R2/R3/R4: every length, normal mode, random data and deletions
        for (int L = 0; L < 4; L++) begin
            char_len = 2'(L);
            random_run(10, 5);
        end

        // R3: a burst of deleted stops, normal mode
        char_len = 2'd3;
        for (int k = 0; k < 4; k++) send_char(9'h0A5 + 9'(k), 1);
        send_char(9'h1FF, 0);
        send_idle(2);
        drain();

        // R5: extended mode, queued characters force short stop gaps
        ext_ovr = 1; char_len = 2'd2; burst = 1;
        for (int k = 0; k < 6; k++) send_char(9'($urandom) | 9'd1, 1);
        send_char(9'h055, 0);
        send_idle(2);
        drain();
        burst = 0;
        chk(min_stop >= LO_SE && min_stop <= LO_SE + 2, "R5 short stop", min_stop, LO_SE);
        random_run(8, 4);
        ext_ovr = 0;

        // R6: break of two character times, then recovery
        char_len = 2'd1;
        send_char(9'h0C3, 0);
        exp_q.push_back(10'h200);
        exp_q.push_back(10'h200);
        for (int i = 0; i < 2 * (nbits() + 2); i++) send_bit(1'b0);
        send_idle(4);
        drain();
        chk(tx_line == 1'b1, "R6 line back high", tx_line, 1);
        send_char(9'h011, 0);
        send_idle(2);
        drain();

        // R7: bypass with a half-received character
        char_len = 2'd0;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        @(negedge clk); bypass = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            rx_bit = 1'($urandom); rx_stb = 1'($urandom);
            #1;
            chk(tx_line == rx_bit && tx_stb == rx_stb, "R7 bypass pass-through",
                {tx_line, tx_stb}, {rx_bit, rx_stb});
        end
        @(negedge clk); rx_bit = 1; rx_stb = 0; bypass = 0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R7 cleared after bypass", tx_line, 1);
        stb_seen = 0;
        send_idle(nbits() + 4);
        chk(stb_seen == 0, "R7 no leftover character", stb_seen, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule